// File: doc/BRIEF.md
# Multicast Port Flush Sweeper

This block walks every slot of a forwarding address table and strips a chosen set of egress ports from the multicast address entries it finds there. A single start pulse launches one complete pass. For each slot the block reads the stored entry and decides whether it qualifies. A qualifying entry has its requested port bits cleared and is written back to the same slot. If no port is left afterwards, the entry is written back as free instead.

The pass can be limited to one VLAN, or it can cover every VLAN when the any-VLAN flag is set. Several kinds of entry are never touched: super entries, the broadcast address, unicast entries, and entries that are not address entries. The table is external. The block drives a read port with one cycle of latency and a write port, and it spends exactly two cycles on every slot.

Top module: `mcast_flush_sweeper`

## Requirements
- R1: A start pulse while idle begins a pass at slot 0 and raises busy in the next cycle. Busy stays high until the last slot has been handled. A start pulse while busy has no effect.
- R2: Every slot takes one read cycle followed by one evaluation cycle, with slots visited in ascending order, so busy is high for exactly 2*DEPTH cycles. Done is high for exactly one cycle, the first cycle after busy falls.
- R3: Only entries whose type field (bits 61:60) is 1 or 3 can be modified. Types 0 (free) and 2 are never written.
- R4: With the any-VLAN flag low, an entry is modified only if its VLAN field (bits 59:48) equals the requested VLAN id. With the flag high, the VLAN field is not compared.
- R5: Only entries with the multicast bit (bit 40) set can be modified.
- R6: Entries with the super bit (bit 65) set are never written.
- R7: Entries whose address (bits 47:0) is all ones are never written.
- R8: The port mask occupies bits 66 upward, one bit per port (NPORTS bits). An entry whose mask has no bit in common with the requested mask is not written.
- R9: A qualifying entry is written back with the requested bits cleared from its mask. Every other bit, including the unused bits above the mask, is preserved.
- R10: If the cleared mask is zero, the entry is written back with its type field set to 0 (free).
- R11: The port mask, VLAN id and any-VLAN flag are sampled on the accepted start pulse. Changes to them during a pass have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one pass |
| flush_mask_i | input | NPORTS | Ports to remove |
| vid_i | input | 12 | VLAN id to restrict the pass to |
| any_vid_i | input | 1 | 1 = match all VLANs |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| rd_en_o | output | 1 | Table read request |
| rd_addr_o | output | AW | Table read slot |
| rd_data_i | input | ENTRY_W | Entry returned one cycle after rd_en_o |
| wr_en_o | output | 1 | Table write request |
| wr_addr_o | output | AW | Table write slot |
| wr_data_o | output | ENTRY_W | Entry to write |

## Verification
The end-of-pass done pulse and the acceptance of a new start can fall in the same cycle, because done is high in the first idle cycle. The bench provokes this by raising start exactly in the cycle where it sees done. It judges the result by checking that busy rises again for a full 2*DEPTH cycles. It also checks that the second pass's writes match the scoreboard, which has been computed from the table as the first pass left it. A further case injects a start pulse and random request inputs in the middle of a pass. That pass must end with no extra writes and no change in its length.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
   localparam int TYPE_LSB  = 60;
   localparam int VID_LSB   = 48;
   localparam int VID_W     = 12;
   localparam int MCAST_BIT = 40;
   localparam int SUPER_BIT = 65;
   localparam int PMASK_LSB = 66;
   localparam int ADDR_W    = 48;

   localparam logic [1:0] KIND_FREE      = 2'd0;
   localparam logic [1:0] KIND_ADDR      = 2'd1;
   localparam logic [1:0] KIND_VLAN_ADDR = 2'd3;

   typedef enum logic [1:0] {
      SW_IDLE = 2'd0,
      SW_READ = 2'd1,
      SW_EVAL = 2'd2
   } sweep_state_e;
endpackage

// File: rtl/mfs_walker.sv
module mfs_walker
   import mfs_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          accept_o,
   output logic          read_ph_o,
   output logic          eval_ph_o,
   output logic [AW-1:0] slot_o
);
   localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

   sweep_state_e  state_q;
   logic [AW-1:0] slot_q;
   logic          done_q;

   assign accept_o  = (state_q == SW_IDLE) && start_i;
   assign read_ph_o = (state_q == SW_READ);
   assign eval_ph_o = (state_q == SW_EVAL);
   assign busy_o    = (state_q != SW_IDLE);
   assign done_o    = done_q;
   assign slot_o    = slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SW_IDLE;
         slot_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SW_IDLE: begin
               if (start_i) begin
                  state_q <= SW_READ;
                  slot_q  <= '0;
               end
            end
            SW_READ: state_q <= SW_EVAL;
            SW_EVAL: begin
               if (slot_q == LAST_SLOT) begin
                  state_q <= SW_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  slot_q  <= slot_q + 1'b1;
                  state_q <= SW_READ;
               end
            end
            default: state_q <= SW_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mfs_entry_edit.sv
module mfs_entry_edit
   import mfs_pkg::*;
#(
   parameter int NPORTS  = 3,
   parameter int ENTRY_W = 72
) (
   input  logic [ENTRY_W-1:0] entry_i,
   input  logic [NPORTS-1:0]  drop_mask_i,
   input  logic [VID_W-1:0]   vid_i,
   input  logic               any_vid_i,
   output logic               modify_o,
   output logic [ENTRY_W-1:0] entry_o
);
   logic [1:0]        kind;
   logic              kind_ok, vid_ok, is_mc, is_super, is_bcast, overlap;
   logic [NPORTS-1:0] old_mask, new_mask;

   always_comb begin
      kind     = entry_i[TYPE_LSB +: 2];
      kind_ok  = (kind == KIND_ADDR) || (kind == KIND_VLAN_ADDR);
      vid_ok   = any_vid_i || (entry_i[VID_LSB +: VID_W] == vid_i);
      is_mc    = entry_i[MCAST_BIT];
      is_super = entry_i[SUPER_BIT];
      is_bcast = &entry_i[ADDR_W-1:0];
      old_mask = entry_i[PMASK_LSB +: NPORTS];
      overlap  = |(old_mask & drop_mask_i);
      new_mask = old_mask & ~drop_mask_i;

      modify_o = kind_ok && vid_ok && is_mc && !is_super && !is_bcast && overlap;

      entry_o = entry_i;
      entry_o[PMASK_LSB +: NPORTS] = new_mask;
      if (new_mask == '0) entry_o[TYPE_LSB +: 2] = KIND_FREE;
   end
endmodule

// File: rtl/mcast_flush_sweeper.sv
module mcast_flush_sweeper
   import mfs_pkg::*;
#(
   parameter int NPORTS  = 3,
   parameter int DEPTH   = 16,
   parameter int ENTRY_W = 72,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [NPORTS-1:0]  flush_mask_i,
   input  logic [11:0]        vid_i,
   input  logic               any_vid_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               rd_en_o,
   output logic [AW-1:0]      rd_addr_o,
   input  logic [ENTRY_W-1:0] rd_data_i,
   output logic               wr_en_o,
   output logic [AW-1:0]      wr_addr_o,
   output logic [ENTRY_W-1:0] wr_data_o
);
   if (NPORTS < 1) begin : g_bad_ports
      $error("NPORTS must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (ENTRY_W < PMASK_LSB + NPORTS) begin : g_bad_width
      $error("ENTRY_W too narrow for the port mask");
   end

   logic              accept, read_ph, eval_ph, modify;
   logic [AW-1:0]     slot;
   logic [NPORTS-1:0] req_mask_q;
   logic [VID_W-1:0]  req_vid_q;
   logic              req_any_q;
   logic [ENTRY_W-1:0] edited;

   mfs_walker #(.DEPTH(DEPTH)) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .accept_o  (accept),
      .read_ph_o (read_ph),
      .eval_ph_o (eval_ph),
      .slot_o    (slot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_mask_q <= '0;
         req_vid_q  <= '0;
         req_any_q  <= 1'b0;
      end else if (accept) begin
         req_mask_q <= flush_mask_i;
         req_vid_q  <= vid_i;
         req_any_q  <= any_vid_i;
      end
   end

   mfs_entry_edit #(.NPORTS(NPORTS), .ENTRY_W(ENTRY_W)) u_edit (
      .entry_i     (rd_data_i),
      .drop_mask_i (req_mask_q),
      .vid_i       (req_vid_q),
      .any_vid_i   (req_any_q),
      .modify_o    (modify),
      .entry_o     (edited)
   );

   assign rd_en_o   = read_ph;
   assign rd_addr_o = slot;
   assign wr_en_o   = eval_ph && modify;
   assign wr_addr_o = slot;
   assign wr_data_o = edited;
endmodule

// File: rtl/mfs_checker.sv
module mfs_checker
   import mfs_pkg::*;
#(
   parameter int NPORTS  = 3,
   parameter int DEPTH   = 16,
   parameter int ENTRY_W = 72,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic [NPORTS-1:0]  flush_mask_i,
   input logic               busy_o,
   input logic               done_o,
   input logic               rd_en_o,
   input logic [AW-1:0]      rd_addr_o,
   input logic               wr_en_o,
   input logic [AW-1:0]      wr_addr_o,
   input logic [ENTRY_W-1:0] wr_data_o
);
   logic [NPORTS-1:0] chk_mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chk_mask_q <= '0;
      else if (start_i && !busy_o) chk_mask_q <= flush_mask_i;
   end

   AST_RD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> busy_o); // R1
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_o && wr_en_o)); // R2
   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> ($past(rd_en_o) && wr_addr_o == $past(rd_addr_o))); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R2
   AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o); // R2
   AST_WR_MCAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> wr_data_o[MCAST_BIT]); // R5
   AST_WR_NO_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !wr_data_o[SUPER_BIT]); // R6
   AST_WR_NO_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !(&wr_data_o[ADDR_W-1:0])); // R7
   AST_WR_BITS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> ((wr_data_o[PMASK_LSB +: NPORTS] & chk_mask_q) == '0)); // R9
   AST_EMPTY_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && wr_data_o[PMASK_LSB +: NPORTS] == '0) |->
      wr_data_o[TYPE_LSB +: 2] == KIND_FREE); // R10
endmodule

bind mcast_flush_sweeper mfs_checker #(
   .NPORTS(NPORTS), .DEPTH(DEPTH), .ENTRY_W(ENTRY_W)
) u_mfs_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .flush_mask_i (flush_mask_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .rd_en_o      (rd_en_o),
   .rd_addr_o    (rd_addr_o),
   .wr_en_o      (wr_en_o),
   .wr_addr_o    (wr_addr_o),
   .wr_data_o    (wr_data_o)
);

// File: tb/tb_mcast_flush_sweeper.sv
module tb_mcast_flush_sweeper;
   localparam int NPORTS  = 3;
   localparam int DEPTH   = 16;
   localparam int ENTRY_W = 72;
   localparam int AW      = $clog2(DEPTH);
   localparam int PM      = 66;

   typedef struct {
      int                 slot;
      logic [ENTRY_W-1:0] data;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic [NPORTS-1:0]  flush_mask_i = '0;
   logic [11:0]        vid_i = '0;
   logic               any_vid_i = 1'b0;
   logic               busy_o, done_o, rd_en_o, wr_en_o;
   logic [AW-1:0]      rd_addr_o, wr_addr_o;
   logic [ENTRY_W-1:0] rd_data_i = '0;
   logic [ENTRY_W-1:0] wr_data_o;

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [ENTRY_W-1:0] exp_tab [DEPTH];
   exp_t               q[$];
   int                 checks = 0;
   int                 errors = 0;
   int unsigned        seed = 32'h1234_5678;
   bit                 poke_mid = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   mcast_flush_sweeper #(.NPORTS(NPORTS), .DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_mask_i(flush_mask_i),
      .vid_i(vid_i), .any_vid_i(any_vid_i), .busy_o(busy_o), .done_o(done_o),
      .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
   );

   // table model: one cycle read latency
   always @(posedge clk) begin
      if (rd_en_o) rd_data_i <= mem[rd_addr_o];
      if (wr_en_o) mem[wr_addr_o] <= wr_data_o;
   end

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   function automatic logic [ENTRY_W-1:0] mk(logic [1:0] kind, logic [11:0] vid,
         logic sup, logic [47:0] addr, logic [NPORTS-1:0] pm);
      logic [ENTRY_W-1:0] e;
      e = '0;
      e[ENTRY_W-1:PM+NPORTS] = '1; // spare bits, must survive (R9)
      e[61:60] = kind;
      e[59:48] = vid;
      e[65]    = sup;
      e[47:0]  = addr;
      e[PM +: NPORTS] = pm;
      return e;
   endfunction

   task automatic check(string req, logic [ENTRY_W-1:0] act, logic [ENTRY_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard driver: expectations derived from the requirements
   task automatic prep(logic [NPORTS-1:0] m, logic [11:0] v, logic any);
      for (int i = 0; i < DEPTH; i++) begin
         logic [ENTRY_W-1:0] e, n;
         logic [NPORTS-1:0]  rem;
         bit ok;
         e  = exp_tab[i];
         ok = (e[61:60] == 2'd1 || e[61:60] == 2'd3)        // R3
              && (any || e[59:48] == v)                       // R4
              && e[40]                                        // R5
              && !e[65]                                       // R6
              && !(&e[47:0])                                  // R7
              && ((e[PM +: NPORTS] & m) != '0);               // R8
         if (ok) begin
            rem = e[PM +: NPORTS] & ~m;                       // R9
            n = e;
            n[PM +: NPORTS] = rem;
            if (rem == '0) n[61:60] = 2'd0;                   // R10
            exp_tab[i] = n;
            q.push_back('{slot: i, data: n});
         end
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected write slot=%0d data=%h expected=no write",
                     wr_addr_o, wr_data_o);
         end else begin
            exp_t x;
            x = q.pop_front();
            check("R2 write slot", ENTRY_W'(wr_addr_o), ENTRY_W'(x.slot));
            check("R9 write data", wr_data_o, x.data);
         end
      end
   end

   // start is expected to be 1 on entry; returns at negedge with done seen
   task automatic run_to_done();
      int n;
      n = 0;
      do begin
         @(negedge clk);
         start_i = 1'b0;
         if (busy_o) n++;
         if (poke_mid && n == 5) begin
            start_i = 1'b1;                // R1: ignored while busy
            flush_mask_i = NPORTS'(rnd());  // R11: ignored mid-pass
            vid_i = 12'(rnd());
            any_vid_i = 1'b0;
         end
      end while (!done_o && n < 4*DEPTH);
      poke_mid = 1'b0;
      check("R2 busy length", ENTRY_W'(n), ENTRY_W'(2*DEPTH));
      check("R2 done with busy low", ENTRY_W'({done_o, busy_o}), ENTRY_W'(2'b10));
      check("R1 writes all consumed", ENTRY_W'(q.size()), ENTRY_W'(0));
      for (int i = 0; i < DEPTH; i++) begin
         string tag;
         case (i)
            0: tag = "R9 partial clear";
            1: tag = "R10 freed";
            2: tag = "R3 type 2 kept";
            3: tag = "R3 free kept";
            4: tag = "R4 other vlan";
            5: tag = "R5 unicast kept";
            6: tag = "R6 super kept";
            7: tag = "R7 broadcast kept";
            8: tag = "R8 no overlap kept";
            default: tag = "R11 table slot";
         endcase
         check(tag, mem[i], exp_tab[i]);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, errors);
      $finish;
   end

   initial begin
      mem[0] = mk(2'd1, 12'd5, 1'b0, 48'h01005e000001, 3'b111);
      mem[1] = mk(2'd3, 12'd5, 1'b0, 48'h01005e000002, 3'b010);
      mem[2] = mk(2'd2, 12'd5, 1'b0, 48'h01005e000003, 3'b010);
      mem[3] = mk(2'd0, 12'd5, 1'b0, 48'h01005e000004, 3'b010);
      mem[4] = mk(2'd1, 12'd7, 1'b0, 48'h01005e000005, 3'b110);
      mem[5] = mk(2'd1, 12'd5, 1'b0, 48'h00aabbccddee, 3'b110);
      mem[6] = mk(2'd1, 12'd5, 1'b1, 48'h01005e000006, 3'b110);
      mem[7] = mk(2'd1, 12'd5, 1'b0, 48'hffffffffffff, 3'b110);
      mem[8] = mk(2'd3, 12'd5, 1'b0, 48'h01005e000007, 3'b101);
      for (int i = 9; i < DEPTH; i++)
         mem[i] = {8'(rnd()), rnd(), rnd()};
      for (int i = 0; i < DEPTH; i++) exp_tab[i] = mem[i];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset busy", ENTRY_W'(busy_o), '0);
      check("R2 reset done", ENTRY_W'(done_o), '0);
      check("R1 reset rd_en", ENTRY_W'(rd_en_o), '0);
      check("R2 reset wr_en", ENTRY_W'(wr_en_o), '0);

      // pass A: port 1 on VLAN 5
      prep(3'b010, 12'd5, 1'b0);
      flush_mask_i = 3'b010; vid_i = 12'd5; any_vid_i = 1'b0;
      start_i = 1'b1;
      run_to_done();

      // pass B: port 2, any VLAN, with mid-pass start and input changes
      @(negedge clk);
      prep(3'b100, 12'd9, 1'b1);
      flush_mask_i = 3'b100; vid_i = 12'd9; any_vid_i = 1'b1;
      poke_mid = 1'b1;
      start_i = 1'b1;
      run_to_done();

      // pass C: started in the very cycle pass B's done is high
      prep(3'b111, 12'd0, 1'b1);
      flush_mask_i = 3'b111; vid_i = 12'd0; any_vid_i = 1'b1;
      start_i = 1'b1;
      run_to_done();

      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end
endmodule